// File: doc/BRIEF.md
# SMBus Bus-Timing Violation Monitor

This block sits beside an SMBus-capable I2C controller and watches the synchronized SCL and SDA levels for timing violations. A configuration bit selects what its continuous timer measures. In low-timeout mode it measures how long SCL stays low without a break. In idle-detect mode it measures how long both lines stay high together, which marks the bus as idle. Two further counters add up the clock-low extension time that each role contributes within one transfer. One counter covers the master role and the other covers the slave role. Each counts only while the protocol engine reports that its role is stretching the clock.

Every counter advances on a single-cycle timeout tick that an external prescaler provides. When a limit is reached, the block sets a sticky timeout flag. It also pulses a request to the master engine to send STOP, or to the slave engine to release both lines, according to the role involved. Separately, a synchronized falling edge on the alert input sets an alert flag, but only when host mode and alert detection are both enabled. Both flags feed one error interrupt, which is gated by an enable bit. Software clears each flag with a write-one-to-clear pulse.

Top module: `smb_timeout_mon`

## Requirements
- R1: With `idle_mode_i`=0, the continuous timer counts ticks while `scl_i`=0. On the tick that brings the count to `limit_a_i`, the timeout event fires, and `tmo_flag_o` reads 1 after that clock edge. With a tick every cycle and limit L≥1, that is exactly L edges after SCL goes low. A limit of 0 never fires.
- R2: The continuous timer clears whenever its watched condition breaks. A break shorter than the limit restarts the full count.
- R3: With `idle_mode_i`=1, the same timer and the same `limit_a_i` apply to the time during which `scl_i`=1 and `sda_i`=1 together.
- R4: The master extension counter counts ticks only while `stretch_m_i`=1. The count is cumulative across gaps. When `ext_en_i`=1 and the count reaches `limit_b_i`, it raises a timeout and a one-cycle `stop_req_o`. `start_i` or `stop_i` clears the count. With `ext_en_i`=0, no extension timeout fires.
- R5: The slave extension counter behaves like the master one. It uses `stretch_s_i`, and its timeout pulses `release_req_o`.
- R6: A continuous-timer timeout pulses `stop_req_o` for one cycle when `master_role_i`=1, and `release_req_o` for one cycle when `master_role_i`=0. The pulse appears in the same cycle that the flag first reads 1.
- R7: `tmo_flag_o` and `alert_flag_o` are sticky. `tmo_clr_i` and `alert_clr_i` clear them one edge later. A set event in the same cycle as the clear keeps the flag at 1.
- R8: `err_irq_o` = `err_ie_i` AND (`tmo_flag_o` OR `alert_flag_o`).
- R9: `alert_i` passes through a two-flop synchronizer and a falling-edge detector. The alert flag reads 1 three edges after `alert_i` falls, and only if `host_en_i`=1 and `alert_en_i`=1.
- R10: After reset, all flags, requests and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle timeout time base |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| idle_mode_i | input | 1 | 0: SCL-low timeout, 1: bus-idle detect |
| master_role_i | input | 1 | 1: controller acts as master |
| limit_a_i | input | 12 | Continuous timer limit (0 = off) |
| limit_b_i | input | 12 | Cumulative extension limit (0 = off) |
| ext_en_i | input | 1 | Enables extension-limit checking |
| stretch_m_i | input | 1 | Master is extending clock low |
| stretch_s_i | input | 1 | Slave is extending clock low |
| start_i | input | 1 | START seen, clears extension counts |
| stop_i | input | 1 | STOP seen, clears extension counts |
| alert_i | input | 1 | Asynchronous alert line |
| host_en_i | input | 1 | Host mode enable |
| alert_en_i | input | 1 | Alert detection enable |
| err_ie_i | input | 1 | Error interrupt enable |
| tmo_clr_i | input | 1 | Write-one-to-clear pulse for timeout flag |
| alert_clr_i | input | 1 | Write-one-to-clear pulse for alert flag |
| stop_req_o | output | 1 | Pulse: master engine must send STOP |
| release_req_o | output | 1 | Pulse: slave engine must release SDA/SCL |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| alert_flag_o | output | 1 | Sticky alert flag |
| err_irq_o | output | 1 | Error interrupt |

## Verification
Two collisions can occur in a single cycle. In the first, a timeout event lands in the same cycle as the write-one-to-clear pulse. The bench provokes this by counting edges to the expected hit and raising `tmo_clr_i` for exactly that edge, then requires the flag to stay set, and to fall only after a later clear on its own. In the second, an alert edge and a continuous-timer timeout complete on the same edge. The bench drops `alert_i` and SCL together with a limit of 3, so that both reach their 3-edge latency together. It then requires both flags, the STOP request and the interrupt in that one sample.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;
  localparam int unsigned CNT_W = 12;

  typedef enum logic {
    WATCH_SCL_LOW = 1'b0,
    WATCH_BUS_IDLE = 1'b1
  } watch_mode_e;

  typedef enum int unsigned {
    ROLE_MST = 0,
    ROLE_SLV = 1
  } role_idx_e;

  localparam int unsigned N_ROLES = 2;
endpackage

// File: rtl/smb_cont_timer.sv
module smb_cont_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cond_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign hit_o   = cond_i && tick_i && (cnt_nxt == {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!cond_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_nxt[CW-1:0];
    end
  end
endmodule

// File: rtl/smb_ext_accum.sv
module smb_ext_accum #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          stretch_i,
  input  logic          clr_i,
  input  logic          chk_en_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] acc_q;
  logic [CW:0]   acc_nxt;
  logic          adv;

  assign acc_nxt = {1'b0, acc_q} + 1'b1;
  assign adv     = tick_i && stretch_i && !clr_i;
  assign hit_o   = chk_en_i && adv && (acc_nxt == {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else if (adv && acc_q != CNT_MAX) begin
      acc_q <= acc_nxt[CW-1:0];
    end
  end
endmodule

// File: rtl/smb_alert_edge.sv
module smb_alert_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alert_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], alert_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q && !sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/smb_sticky_flag.sv
module smb_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/smb_timeout_mon.sv
module smb_timeout_mon
  import smb_tmo_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          idle_mode_i,
  input  logic          master_role_i,
  input  logic [CW-1:0] limit_a_i,
  input  logic [CW-1:0] limit_b_i,
  input  logic          ext_en_i,
  input  logic          stretch_m_i,
  input  logic          stretch_s_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          alert_i,
  input  logic          host_en_i,
  input  logic          alert_en_i,
  input  logic          err_ie_i,
  input  logic          tmo_clr_i,
  input  logic          alert_clr_i,
  output logic          stop_req_o,
  output logic          release_req_o,
  output logic          tmo_flag_o,
  output logic          alert_flag_o,
  output logic          err_irq_o
);
  logic               watch_cond;
  logic               hit_a;
  logic [N_ROLES-1:0] stretch_vec;
  logic [N_ROLES-1:0] hit_b;
  logic               alert_fall;
  logic               tmo_set;
  logic               alert_set;
  logic               stop_d, rel_d;

  assign watch_cond = (watch_mode_e'(idle_mode_i) == WATCH_BUS_IDLE) ? (scl_i && sda_i) : !scl_i;

  smb_cont_timer #(.CW(CW)) u_cont (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .cond_i  (watch_cond),
    .limit_i (limit_a_i),
    .hit_o   (hit_a)
  );

  assign stretch_vec[ROLE_MST] = stretch_m_i;
  assign stretch_vec[ROLE_SLV] = stretch_s_i;

  for (genvar r = 0; r < N_ROLES; r++) begin : g_ext
    smb_ext_accum #(.CW(CW)) u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .stretch_i (stretch_vec[r]),
      .clr_i     (start_i || stop_i),
      .chk_en_i  (ext_en_i),
      .limit_i   (limit_b_i),
      .hit_o     (hit_b[r])
    );
  end

  smb_alert_edge #(.SYNC_STAGES(2)) u_alert (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alert_i (alert_i),
    .fall_o  (alert_fall)
  );

  assign tmo_set   = hit_a || (|hit_b);
  assign alert_set = alert_fall && host_en_i && alert_en_i;
  assign stop_d    = (hit_a && master_role_i) || hit_b[ROLE_MST];
  assign rel_d     = (hit_a && !master_role_i) || hit_b[ROLE_SLV];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_req_o    <= 1'b0;
      release_req_o <= 1'b0;
    end else begin
      stop_req_o    <= stop_d;
      release_req_o <= rel_d;
    end
  end

  smb_sticky_flag u_tmo_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tmo_set),
    .clr_i  (tmo_clr_i),
    .flag_o (tmo_flag_o)
  );

  smb_sticky_flag u_alert_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (alert_set),
    .clr_i  (alert_clr_i),
    .flag_o (alert_flag_o)
  );

  assign err_irq_o = err_ie_i && (tmo_flag_o || alert_flag_o);
endmodule

// File: rtl/smb_timeout_mon_chk.sv
module smb_timeout_mon_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic host_en_i,
  input logic alert_en_i,
  input logic err_ie_i,
  input logic tmo_clr_i,
  input logic alert_clr_i,
  input logic stop_req_o,
  input logic release_req_o,
  input logic tmo_flag_o,
  input logic alert_flag_o,
  input logic err_irq_o
);
  // R7
  tmo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_flag_o && !tmo_clr_i) |=> tmo_flag_o);

  // R7
  alert_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_flag_o && !alert_clr_i) |=> alert_flag_o);

  // R6
  stop_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o |-> tmo_flag_o);

  // R6
  release_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_req_o |-> tmo_flag_o);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_ie_i |-> !err_irq_o);

  // R9
  alert_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_flag_o) |-> $past(host_en_i && alert_en_i));
endmodule

bind smb_timeout_mon smb_timeout_mon_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_en_i     (host_en_i),
  .alert_en_i    (alert_en_i),
  .err_ie_i      (err_ie_i),
  .tmo_clr_i     (tmo_clr_i),
  .alert_clr_i   (alert_clr_i),
  .stop_req_o    (stop_req_o),
  .release_req_o (release_req_o),
  .tmo_flag_o    (tmo_flag_o),
  .alert_flag_o  (alert_flag_o),
  .err_irq_o     (err_irq_o)
);

// File: tb/smb_timeout_mon_bench.sv
`timescale 1ns/1ps
module smb_timeout_mon_bench;
  localparam int CW = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i, scl_i, sda_i, idle_mode_i, master_role_i;
  logic [CW-1:0] limit_a_i, limit_b_i;
  logic ext_en_i, stretch_m_i, stretch_s_i, start_i, stop_i;
  logic alert_i, host_en_i, alert_en_i, err_ie_i, tmo_clr_i, alert_clr_i;
  logic stop_req_o, release_req_o, tmo_flag_o, alert_flag_o, err_irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  smb_timeout_mon u_smb_timeout_mon (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic neutral();
    scl_i = 1'b1; sda_i = 1'b0;
    stretch_m_i = 1'b0; stretch_s_i = 1'b0;
    start_i = 1'b1; tmo_clr_i = 1'b1; alert_clr_i = 1'b1;
    cyc(2);
    start_i = 1'b0; tmo_clr_i = 1'b0; alert_clr_i = 1'b0;
  endtask

  // hold the watched condition and find the edge count at which the flag rises
  task automatic cont_sweep(input logic mode, input int lim, input logic role);
    int first;
    logic st, rl;
    idle_mode_i = mode; master_role_i = role; limit_a_i = CW'(lim);
    neutral();
    first = 0; st = 1'b0; rl = 1'b0;
    if (mode) begin scl_i = 1'b1; sda_i = 1'b1; end
    else      begin scl_i = 1'b0; end
    for (int n = 1; n <= 20; n++) begin
      cyc(1);
      if (tmo_flag_o && first == 0) begin
        first = n; st = stop_req_o; rl = release_req_o;
      end
    end
    n_run++;
    if (first != lim) begin
      n_fail++;
      $display("FAIL %s: limit %0d flag after %0d expected %0d",
               mode ? "R3" : "R1", lim, first, lim);
    end
    chk("R6 stop", st, role);
    chk("R6 release", rl, !role);
  endtask

  task automatic ext_run(input logic slv, input int lim);
    int first;
    limit_a_i = '0; limit_b_i = CW'(lim); ext_en_i = 1'b1; idle_mode_i = 1'b0;
    neutral();
    first = 0;
    if (slv) stretch_s_i = 1'b1; else stretch_m_i = 1'b1;
    for (int n = 1; n <= 10; n++) begin
      cyc(1);
      if (tmo_flag_o && first == 0) begin
        first = n;
        chk(slv ? "R5 release" : "R4 stop", slv ? release_req_o : stop_req_o, 1'b1);
      end
    end
    n_run++;
    if (first != lim) begin
      n_fail++;
      $display("FAIL %s: limit %0d flag after %0d expected %0d",
               slv ? "R5" : "R4", lim, first, lim);
    end
  endtask

  initial begin
    tick_i = 1'b1; scl_i = 1'b1; sda_i = 1'b0; idle_mode_i = 1'b0; master_role_i = 1'b1;
    limit_a_i = '0; limit_b_i = '0; ext_en_i = 1'b0;
    stretch_m_i = 1'b0; stretch_s_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    alert_i = 1'b1; host_en_i = 1'b1; alert_en_i = 1'b1; err_ie_i = 1'b1;
    tmo_clr_i = 1'b0; alert_clr_i = 1'b0;
    cyc(2);
    // R10 reset state
    chk("R10 tmo", tmo_flag_o, 1'b0);
    chk("R10 alert", alert_flag_o, 1'b0);
    chk("R10 stop", stop_req_o, 1'b0);
    chk("R10 release", release_req_o, 1'b0);
    chk("R10 irq", err_irq_o, 1'b0);
    rst_ni = 1'b1;
    cyc(1);

    // R1 / R3 / R6 sweeps over limit, mode and role
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 2; r++)
        for (int l = 1; l <= 7; l++)
          cont_sweep(m[0], l, r[0]);

    // R1 limit 0 never fires
    idle_mode_i = 1'b0; limit_a_i = '0; neutral();
    scl_i = 1'b0; cyc(15);
    chk("R1 limit0", tmo_flag_o, 1'b0);

    // R2 break restarts count
    limit_a_i = 12'd4; neutral();
    scl_i = 1'b0; cyc(3); scl_i = 1'b1; cyc(1); scl_i = 1'b0; cyc(3);
    chk("R2 break", tmo_flag_o, 1'b0);
    cyc(1);
    chk("R2 restart", tmo_flag_o, 1'b1);

    // R3 sda low breaks idle count
    idle_mode_i = 1'b1; limit_a_i = 12'd3; neutral();
    scl_i = 1'b1; sda_i = 1'b1; cyc(2); sda_i = 1'b0; cyc(1); sda_i = 1'b1; cyc(2);
    chk("R3 break", tmo_flag_o, 1'b0);
    cyc(1);
    chk("R3 restart", tmo_flag_o, 1'b1);

    // R4 / R5 sweeps
    for (int l = 1; l <= 6; l++) begin
      ext_run(1'b0, l);
      ext_run(1'b1, l);
    end

    // R4 cumulative with gaps; tick gating
    limit_a_i = '0; limit_b_i = 12'd4; ext_en_i = 1'b1; idle_mode_i = 1'b0; neutral();
    stretch_m_i = 1'b1; cyc(2); stretch_m_i = 1'b0; cyc(3);
    stretch_m_i = 1'b1; tick_i = 1'b0; cyc(3); tick_i = 1'b1; cyc(1);
    chk("R4 accum", tmo_flag_o, 1'b0);
    cyc(1);
    chk("R4 accum hit", tmo_flag_o, 1'b1);
    chk("R4 stop", stop_req_o, 1'b1);
    stretch_m_i = 1'b0;

    // R4 start/stop clears count
    neutral();
    stretch_m_i = 1'b1; cyc(3); stretch_m_i = 1'b0; stop_i = 1'b1; cyc(1); stop_i = 1'b0;
    stretch_m_i = 1'b1; cyc(3);
    chk("R4 clear", tmo_flag_o, 1'b0);
    cyc(1);
    chk("R4 after clear", tmo_flag_o, 1'b1);

    // R5 start clears slave count; R4 ext_en gate
    neutral();
    stretch_s_i = 1'b1; cyc(3); stretch_s_i = 1'b0; start_i = 1'b1; cyc(1); start_i = 1'b0;
    stretch_s_i = 1'b1; cyc(3);
    chk("R5 clear", tmo_flag_o, 1'b0);
    ext_en_i = 1'b0; neutral();
    stretch_m_i = 1'b1; stretch_s_i = 1'b1; cyc(8);
    chk("R4 ext disabled", tmo_flag_o, 1'b0);
    stretch_m_i = 1'b0; stretch_s_i = 1'b0;

    // R7 hit and clear in the same cycle: set wins
    idle_mode_i = 1'b0; master_role_i = 1'b1; limit_a_i = 12'd3; neutral();
    scl_i = 1'b0; cyc(2); tmo_clr_i = 1'b1; cyc(1); tmo_clr_i = 1'b0;
    chk("R7 set wins", tmo_flag_o, 1'b1);
    scl_i = 1'b1; cyc(2);
    chk("R7 sticky", tmo_flag_o, 1'b1);
    tmo_clr_i = 1'b1; cyc(1); tmo_clr_i = 1'b0;
    chk("R7 clear", tmo_flag_o, 1'b0);

    // R9 alert latency and gating
    alert_i = 1'b0; cyc(2);
    chk("R9 latency early", alert_flag_o, 1'b0);
    cyc(1);
    chk("R9 alert set", alert_flag_o, 1'b1);
    chk("R8 irq on alert", err_irq_o, 1'b1);
    err_ie_i = 1'b0; #1;
    chk("R8 irq gated", err_irq_o, 1'b0);
    err_ie_i = 1'b1;
    alert_i = 1'b1; alert_clr_i = 1'b1; cyc(1); alert_clr_i = 1'b0; cyc(3);
    chk("R7 alert clear", alert_flag_o, 1'b0);
    host_en_i = 1'b0; alert_i = 1'b0; cyc(5);
    chk("R9 host gate", alert_flag_o, 1'b0);
    alert_i = 1'b1; cyc(4); host_en_i = 1'b1; alert_en_i = 1'b0; alert_i = 1'b0; cyc(5);
    chk("R9 enable gate", alert_flag_o, 1'b0);
    chk("R8 irq idle", err_irq_o, 1'b0);
    alert_i = 1'b1; alert_en_i = 1'b1; cyc(4);

    // R7/R9 alert and timeout on the same edge
    limit_a_i = 12'd3; neutral();
    scl_i = 1'b0; alert_i = 1'b0; cyc(2);
    chk("R9 both early", alert_flag_o | tmo_flag_o, 1'b0);
    cyc(1);
    chk("R9 both alert", alert_flag_o, 1'b1);
    chk("R1 both tmo", tmo_flag_o, 1'b1);
    chk("R6 both stop", stop_req_o, 1'b1);
    chk("R8 both irq", err_irq_o, 1'b1);
    cyc(1);
    chk("R6 pulse width", stop_req_o, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule